// File: doc/BRIEF.md
# NAND Flash Bad-Block Scan Engine

After reset this block visits every erase block of a serial NAND flash in ascending order. It builds a one-bit-per-block map of bad blocks and a count of them. For each block it sends a page-load command through an external SPI byte engine for the first page of that block. It then hands control to an external status poller and waits until the device is ready. Last, it reads 16 bytes from the spare area of the loaded page and inspects them.

A block is bad when either of two independent marks is present. The first is a factory mark: the first spare byte is anything other than the erased value. The second is a user mark: a fixed 32-bit signature in spare bytes 8 to 11. The scan needs no start command. When the last block has been judged, a done flag rises and the engine goes quiet. If the device stays busy, or the byte engine reports a transport fault, the scan stops at once with an error code.

The map sits in an internal register array. A lookup port returns the stored bit for any block index one clock after the index is presented.

Top module: `nbs_scan_top`

## Requirements
- R1: Blocks are visited in order 0, 1, ..., NUM_BLOCKS-1. For block j the engine sends a 4-byte load transaction: 0x13, 0x00, row[15:8], row[7:0], where row = j << 6. `tx_end` is high only with the fourth byte.
- R2: After the load transaction the engine holds `poll_req` high until `poll_done`. `poll_req` and `tx_valid` are never high together.
- R3: After a ready poll the engine sends a 20-byte read transaction: 0x03, 0x08, 0x00, 0x00, then sixteen 0x00 bytes. The `rx_byte` values of those sixteen bytes are spare bytes 0 to 15. `tx_end` is high only with the twentieth byte.
- R4: A block whose spare byte 0 is not 0xFF is marked bad.
- R5: A block is marked bad when spare bytes 8, 9, 10 and 11 form 0xDEADBEEF with byte 8 as the least significant byte (EF, BE, AD, DE on the wire). Any other value, including the reversed byte order or a single wrong bit, leaves the mark clear.
- R6: `bad_count` is 11 bits wide and rises by exactly one for each block judged bad, including a block that carries both marks. It never decreases while out of reset.
- R7: `scan_done` rises after the last block is judged and stays high. After that no further byte or poll request is issued.
- R8: `lk_bad` shows the map bit of the block at `lk_idx` one clock after `lk_idx` is applied.
- R9: `poll_done` with `poll_stuck` high aborts the scan. `scan_err` rises, `err_code` becomes 2, and `scan_done` stays low. No further byte or poll request follows, and blocks not yet judged read as good.
- R10: `byte_done` with `xfer_err` high aborts the scan. `scan_err` rises, `err_code` becomes 1, and no further byte or poll request follows.
- R11: Reset clears the whole map, `bad_count`, `scan_done`, `scan_err` and `err_code`.
- R12: Once `tx_valid` is high it stays high, with `tx_byte` unchanged, until a clock on which `byte_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; scan starts on release |
| tx_valid | output | 1 | Byte request to the SPI byte engine |
| tx_byte | output | 8 | Byte to shift out |
| tx_end | output | 1 | Last byte of the current transaction (release chip select) |
| byte_done | input | 1 | Byte engine finished the requested byte |
| rx_byte | input | 8 | Byte shifted in, valid with `byte_done` |
| xfer_err | input | 1 | Transport fault, valid with `byte_done` |
| poll_req | output | 1 | Request to the status poller |
| poll_done | input | 1 | Poller finished |
| poll_stuck | input | 1 | Device never became ready, valid with `poll_done` |
| lk_idx | input | 10 | Block index for a map lookup |
| lk_bad | output | 1 | Map bit of the looked-up block, one clock later |
| bad_count | output | 11 | Number of blocks judged bad so far |
| scan_done | output | 1 | Scan completed without error |
| scan_err | output | 1 | Scan aborted |
| err_code | output | 2 | 0 none, 1 transport fault, 2 device stuck |

## Verification
A wrong byte index or row register shows up on the very next requested byte. The scoreboard compares every byte and every `tx_end` against the expected stream, so it fails within one handshake. A mis-captured spare byte or a broken signature compare stays hidden until the map is read or the scan ends. It then shows as a wrong `lk_bad` bit for that block and a wrong `bad_count`. The error paths are forced at a chosen block and a chosen byte, and the bench checks that traffic stops within a handshake.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

   localparam logic [7:0] OP_PAGE_LOAD  = 8'h13;
   localparam logic [7:0] OP_CACHE_READ = 8'h03;
   localparam logic [7:0] SPARE_COL_HI  = 8'h08;
   localparam logic [7:0] SPARE_COL_LO  = 8'h00;
   localparam logic [7:0] PAD_BYTE      = 8'h00;
   localparam logic [7:0] ERASED_BYTE   = 8'hFF;

   localparam int LOAD_BYTES     = 4;
   localparam int READ_HDR_BYTES = 4;
   localparam int ROW_W          = 16;

   typedef enum logic [2:0] {
      SQ_LOAD,
      SQ_POLL,
      SQ_READ,
      SQ_EVAL,
      SQ_DONE,
      SQ_FAIL
   } seq_state_t;

   typedef enum logic [1:0] {
      ERR_NONE  = 2'd0,
      ERR_XFER  = 2'd1,
      ERR_STUCK = 2'd2
   } scan_err_t;

endpackage

// File: rtl/nbs_cmd_seq.sv
module nbs_cmd_seq
   import nbs_pkg::*;
#(
   parameter int NUM_BLOCKS = 1024,
   parameter int BLK_W      = 10,
   parameter int PAGE_SHIFT = 6,
   parameter int SPARE_LEN  = 16,
   localparam int CAP_W     = $clog2(SPARE_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             tx_valid,
   output logic [7:0]       tx_byte,
   output logic             tx_end,
   input  logic             byte_done,
   input  logic [7:0]       rx_byte,
   input  logic             xfer_err,
   output logic             poll_req,
   input  logic             poll_done,
   input  logic             poll_stuck,
   output logic             cap_valid,
   output logic [CAP_W-1:0] cap_idx,
   output logic [7:0]       cap_byte,
   output logic             eval_go,
   output logic [BLK_W-1:0] eval_blk,
   output logic             scan_done,
   output logic             scan_err,
   output logic [1:0]       err_code
);

   localparam int READ_BYTES = READ_HDR_BYTES + SPARE_LEN;
   localparam int IDX_W      = $clog2(READ_BYTES + 1);
   localparam logic [IDX_W-1:0] LOAD_LAST = IDX_W'(LOAD_BYTES - 1);
   localparam logic [IDX_W-1:0] READ_LAST = IDX_W'(READ_BYTES - 1);
   localparam logic [IDX_W-1:0] HDR_N     = IDX_W'(READ_HDR_BYTES);
   localparam logic [BLK_W-1:0] BLK_LAST  = BLK_W'(NUM_BLOCKS - 1);

   seq_state_t        state;
   scan_err_t         err_q;
   logic [IDX_W-1:0]  idx;
   logic [BLK_W-1:0]  blk;
   logic [ROW_W-1:0]  row;

   assign row = ROW_W'(blk) << PAGE_SHIFT;

   // byte selection for the two transactions
   always_comb begin
      tx_valid = 1'b0;
      tx_byte  = PAD_BYTE;
      tx_end   = 1'b0;
      unique case (state)
         SQ_LOAD: begin
            tx_valid = 1'b1;
            tx_end   = (idx == LOAD_LAST);
            unique case (idx)
               IDX_W'(0): tx_byte = OP_PAGE_LOAD;
               IDX_W'(1): tx_byte = 8'h00;
               IDX_W'(2): tx_byte = row[15:8];
               default:   tx_byte = row[7:0];
            endcase
         end
         SQ_READ: begin
            tx_valid = 1'b1;
            tx_end   = (idx == READ_LAST);
            unique case (idx)
               IDX_W'(0): tx_byte = OP_CACHE_READ;
               IDX_W'(1): tx_byte = SPARE_COL_HI;
               IDX_W'(2): tx_byte = SPARE_COL_LO;
               default:   tx_byte = PAD_BYTE;
            endcase
         end
         default: ;
      endcase
   end

   assign poll_req  = (state == SQ_POLL);
   assign cap_valid = (state == SQ_READ) && byte_done && !xfer_err && (idx >= HDR_N);
   assign cap_idx   = CAP_W'(idx - HDR_N);
   assign cap_byte  = rx_byte;
   assign eval_go   = (state == SQ_EVAL);
   assign eval_blk  = blk;
   assign scan_done = (state == SQ_DONE);
   assign scan_err  = (state == SQ_FAIL);
   assign err_code  = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_LOAD;
         err_q <= ERR_NONE;
         idx   <= '0;
         blk   <= '0;
      end else begin
         unique case (state)
            SQ_LOAD, SQ_READ: begin
               if (byte_done) begin
                  if (xfer_err) begin
                     state <= SQ_FAIL;
                     err_q <= ERR_XFER;
                  end else if (tx_end) begin
                     idx   <= '0;
                     state <= (state == SQ_LOAD) ? SQ_POLL : SQ_EVAL;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            SQ_POLL: begin
               if (poll_done) begin
                  if (poll_stuck) begin
                     state <= SQ_FAIL;
                     err_q <= ERR_STUCK;
                  end else begin
                     state <= SQ_READ;
                  end
               end
            end
            SQ_EVAL: begin
               if (blk == BLK_LAST) begin
                  state <= SQ_DONE;
               end else begin
                  blk   <= blk + 1'b1;
                  state <= SQ_LOAD;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/nbs_mark_eval.sv
module nbs_mark_eval
   import nbs_pkg::*;
#(
   parameter int          SPARE_LEN     = 16,
   parameter int          FACT_OFF      = 0,
   parameter int          SIG_OFF       = 8,
   parameter logic [31:0] SIG_VAL       = 32'hDEAD_BEEF,
   parameter bit          SIG_LSB_FIRST = 1'b1,
   localparam int         CAP_W         = $clog2(SPARE_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_valid,
   input  logic [CAP_W-1:0] cap_idx,
   input  logic [7:0]       cap_byte,
   input  logic             clr,
   output logic             blk_bad
);

   localparam int SIG_BYTES = 4;

   logic        fact_bad;
   logic [31:0] sig_q;
   logic [31:0] sig_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fact_bad <= 1'b0;
         sig_q    <= '0;
      end else if (clr) begin
         fact_bad <= 1'b0;
         sig_q    <= '0;
      end else if (cap_valid) begin
         if (cap_idx == CAP_W'(FACT_OFF))
            fact_bad <= (cap_byte != ERASED_BYTE);
         for (int k = 0; k < SIG_BYTES; k++) begin
            if (cap_idx == CAP_W'(SIG_OFF + k))
               sig_q[8*k +: 8] <= cap_byte;
         end
      end
   end

   // byte order of the signature on the wire
   generate
      if (SIG_LSB_FIRST) begin : g_lsb_first
         assign sig_seen = sig_q;
      end else begin : g_msb_first
         assign sig_seen = {sig_q[7:0], sig_q[15:8], sig_q[23:16], sig_q[31:24]};
      end
   endgenerate

   assign blk_bad = fact_bad | (sig_seen == SIG_VAL);

endmodule

// File: rtl/nbs_bad_map.sv
module nbs_bad_map #(
   parameter int  NUM_BLOCKS = 1024,
   parameter int  BLK_W      = 10,
   localparam int CNT_W      = BLK_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BLK_W-1:0] wr_idx,
   input  logic             wr_bad,
   input  logic [BLK_W-1:0] lk_idx,
   output logic             lk_bad,
   output logic [CNT_W-1:0] bad_count
);

   logic [NUM_BLOCKS-1:0] map_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q     <= '0;
         bad_count <= '0;
      end else if (wr_en) begin
         map_q[wr_idx] <= wr_bad;
         bad_count     <= bad_count + CNT_W'(wr_bad);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lk_bad <= 1'b0;
      else
         lk_bad <= (32'(lk_idx) < NUM_BLOCKS) ? map_q[lk_idx] : 1'b0;
   end

endmodule

// File: rtl/nbs_scan_top.sv
module nbs_scan_top
   import nbs_pkg::*;
#(
   parameter int  NUM_BLOCKS = 1024,
   parameter int  PAGE_SHIFT = 6,
   parameter int  SPARE_LEN  = 16,
   parameter int  SIG_OFF    = 8,
   localparam int BLK_W      = $clog2(NUM_BLOCKS),
   localparam int CNT_W      = BLK_W + 1,
   localparam int CAP_W      = $clog2(SPARE_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             tx_valid,
   output logic [7:0]       tx_byte,
   output logic             tx_end,
   input  logic             byte_done,
   input  logic [7:0]       rx_byte,
   input  logic             xfer_err,
   output logic             poll_req,
   input  logic             poll_done,
   input  logic             poll_stuck,
   input  logic [BLK_W-1:0] lk_idx,
   output logic             lk_bad,
   output logic [CNT_W-1:0] bad_count,
   output logic             scan_done,
   output logic             scan_err,
   output logic [1:0]       err_code
);

   generate
      if (BLK_W + PAGE_SHIFT > ROW_W) begin : g_row_too_wide
         $error("block index and page shift exceed the row address");
      end
      if (SIG_OFF + 4 > SPARE_LEN) begin : g_sig_outside
         $error("signature lies outside the captured spare bytes");
      end
      if (NUM_BLOCKS < 2) begin : g_too_few
         $error("at least two blocks required");
      end
   endgenerate

   logic             cap_valid;
   logic [CAP_W-1:0] cap_idx;
   logic [7:0]       cap_byte;
   logic             eval_go;
   logic [BLK_W-1:0] eval_blk;
   logic             blk_bad;

   nbs_cmd_seq #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .BLK_W      (BLK_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .SPARE_LEN  (SPARE_LEN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_valid   (tx_valid),
      .tx_byte    (tx_byte),
      .tx_end     (tx_end),
      .byte_done  (byte_done),
      .rx_byte    (rx_byte),
      .xfer_err   (xfer_err),
      .poll_req   (poll_req),
      .poll_done  (poll_done),
      .poll_stuck (poll_stuck),
      .cap_valid  (cap_valid),
      .cap_idx    (cap_idx),
      .cap_byte   (cap_byte),
      .eval_go    (eval_go),
      .eval_blk   (eval_blk),
      .scan_done  (scan_done),
      .scan_err   (scan_err),
      .err_code   (err_code)
   );

   nbs_mark_eval #(
      .SPARE_LEN     (SPARE_LEN),
      .FACT_OFF      (0),
      .SIG_OFF       (SIG_OFF),
      .SIG_VAL       (32'hDEAD_BEEF),
      .SIG_LSB_FIRST (1'b1)
   ) u_eval (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_valid (cap_valid),
      .cap_idx   (cap_idx),
      .cap_byte  (cap_byte),
      .clr       (eval_go),
      .blk_bad   (blk_bad)
   );

   nbs_bad_map #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .BLK_W      (BLK_W)
   ) u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (eval_go),
      .wr_idx    (eval_blk),
      .wr_bad    (blk_bad),
      .lk_idx    (lk_idx),
      .lk_bad    (lk_bad),
      .bad_count (bad_count)
   );

endmodule

// File: rtl/nbs_scan_chk.sv
module nbs_scan_chk #(
   parameter int CNT_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_valid,
   input logic [7:0]       tx_byte,
   input logic             byte_done,
   input logic             poll_req,
   input logic             scan_done,
   input logic             scan_err,
   input logic [1:0]       err_code,
   input logic [CNT_W-1:0] bad_count
);

   // R12
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !byte_done) |=> (tx_valid && $stable(tx_byte)));

   // R2
   poll_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(poll_req && tx_valid));

   // R7
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> scan_done);

   // R7
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> (!tx_valid && !poll_req));

   // R9
   fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_err |-> (!tx_valid && !poll_req && !scan_done));

   // R10
   err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_err == (err_code != 2'd0));

   // R6
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_count != $past(bad_count)) |-> (bad_count == $past(bad_count) + 1'b1));

endmodule

bind nbs_scan_top nbs_scan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_valid  (tx_valid),
   .tx_byte   (tx_byte),
   .byte_done (byte_done),
   .poll_req  (poll_req),
   .scan_done (scan_done),
   .scan_err  (scan_err),
   .err_code  (err_code),
   .bad_count (bad_count)
);

// File: tb/sim_nbs_scan_top.sv
module sim_nbs_scan_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB         = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_valid;
   logic [7:0] tx_byte;
   logic       tx_end;
   logic       byte_done = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       xfer_err = 1'b0;
   logic       poll_req;
   logic       poll_done = 1'b0;
   logic       poll_stuck = 1'b0;
   logic [9:0] lk_idx = '0;
   logic       lk_bad;
   logic [10:0] bad_count;
   logic       scan_done;
   logic       scan_err;
   logic [1:0] err_code;

   int vec_cnt = 0;
   int miss_cnt = 0;
   bit finished = 0;

   logic [8:0] exp_q[$];
   int stuck_blk = -1;
   int err_at = -1;
   int byte_num = 0;
   int tcnt = 0;
   logic [7:0] op = 8'h00;
   logic [15:0] row_seen = '0;
   int cur_blk = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nbs_scan_top u0 (
      .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_end(tx_end),
      .byte_done(byte_done), .rx_byte(rx_byte), .xfer_err(xfer_err),
      .poll_req(poll_req), .poll_done(poll_done), .poll_stuck(poll_stuck),
      .lk_idx(lk_idx), .lk_bad(lk_bad), .bad_count(bad_count),
      .scan_done(scan_done), .scan_err(scan_err), .err_code(err_code)
   );

   // flash content model
   function automatic logic [7:0] fbyte(int j);
      if (j % 7 == 3)   return 8'h00;
      if (j % 23 == 9)  return 8'hFE;
      return 8'hFF;
   endfunction

   // 0 none, 1 valid signature, 2 one bit off, 3 reversed order
   function automatic int sig_kind(int j);
      if (j % 11 == 5) return 1;
      if (j % 17 == 2) return 2;
      if (j % 19 == 4) return 3;
      return 0;
   endfunction

   function automatic logic [7:0] spare(int j, int k);
      logic [31:0] w;
      if (k == 0) return fbyte(j);
      if (k < 8 || k > 11) return 8'hFF;
      case (sig_kind(j))
         1: w = 32'hDEADBEEF;
         2: w = 32'hDEADBEEE;
         3: w = 32'hEFBEADDE;
         default: return 8'hFF;
      endcase
      return w[8*(k-8) +: 8];
   endfunction

   function automatic bit exp_bad(int j);
      return (fbyte(j) != 8'hFF) || (sig_kind(j) == 1);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      vec_cnt++;
      if (!ok) begin
         miss_cnt++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_block(int j, int n);
      logic [8:0] b[24];
      logic [15:0] row;
      row = 16'(j) << 6;
      b[0] = {1'b0, 8'h13};
      b[1] = {1'b0, 8'h00};
      b[2] = {1'b0, row[15:8]};
      b[3] = {1'b1, row[7:0]};
      b[4] = {1'b0, 8'h03};
      b[5] = {1'b0, 8'h08};
      b[6] = {1'b0, 8'h00};
      b[7] = {1'b0, 8'h00};
      for (int k = 8; k < 24; k++) b[k] = {(k == 23), 8'h00};
      for (int k = 0; k < n; k++) exp_q.push_back(b[k]);
   endtask

   // byte engine model and scoreboard monitor
   initial forever begin
      @(negedge clk);
      if (!rst_n) begin
         byte_done = 1'b0;
         xfer_err  = 1'b0;
         tcnt      = 0;
      end else if (byte_done) begin
         byte_done = 1'b0;
         xfer_err  = 1'b0;
      end else if (tx_valid) begin
         logic [8:0] e;
         byte_num++;
         if (tcnt == 0) op = tx_byte;
         if (exp_q.size() == 0) begin
            check(1'b0, "R7", {tx_end, tx_byte}, 9'h1FF);
         end else begin
            e = exp_q.pop_front();
            if (op == 8'h13)
               check({tx_end, tx_byte} == e, "R1", {tx_end, tx_byte}, e);
            else
               check({tx_end, tx_byte} == e, "R3", {tx_end, tx_byte}, e);
         end
         if (op == 8'h13 && tcnt == 2) row_seen[15:8] = tx_byte;
         if (op == 8'h13 && tcnt == 3) begin
            row_seen[7:0] = tx_byte;
            cur_blk = int'(row_seen >> 6);
         end
         rx_byte   = (op == 8'h03 && tcnt >= 4) ? spare(cur_blk, tcnt - 4) : 8'h5A;
         xfer_err  = (byte_num == err_at);
         tcnt      = tx_end ? 0 : tcnt + 1;
         byte_done = 1'b1;
      end
   end

   // status poller model
   initial forever begin
      @(negedge clk);
      if (!rst_n || poll_done) begin
         poll_done  = 1'b0;
         poll_stuck = 1'b0;
      end else if (poll_req) begin
         poll_done  = 1'b1;
         poll_stuck = (cur_blk == stuck_blk);
      end
   end

   task automatic hold_reset();
      @(negedge clk);
      rst_n = 1'b0;
      exp_q.delete();
      byte_num = 0;
      repeat (3) @(negedge clk);
      // R11
      check(scan_done == 1'b0, "R11", scan_done, 0);
      check(scan_err == 1'b0, "R11", scan_err, 0);
      check(bad_count == 11'd0, "R11", bad_count, 0);
      check(err_code == 2'd0, "R11", err_code, 0);
   endtask

   task automatic release_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_end();
      while (!scan_done && !scan_err) @(negedge clk);
   endtask

   task automatic lookup(int j, output logic v);
      lk_idx = 10'(j);
      @(negedge clk);
      v = lk_bad;
   endtask

   task automatic idle_check(string req);
      repeat (6) begin
         @(negedge clk);
         check(!tx_valid && !poll_req, req, {tx_valid, poll_req}, 0);
      end
      check(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!finished) begin
         finished = 1;
         miss_cnt++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
         $finish;
      end
   end

   initial begin
      logic v;
      int exp_cnt;

      // full scan
      hold_reset();
      for (int j = 0; j < NB; j++) push_block(j, 24);
      release_reset();
      wait_end();
      exp_cnt = 0;
      for (int j = 0; j < NB; j++) exp_cnt += int'(exp_bad(j));
      // R7
      check(scan_done && !scan_err, "R7", {scan_done, scan_err}, 2'b10);
      // R6 (block 38 carries both marks)
      check(int'(bad_count) == exp_cnt, "R6", bad_count, exp_cnt);
      idle_check("R7");
      for (int j = 0; j < NB; j++) begin
         lookup(j, v);
         if (fbyte(j) != 8'hFF)
            check(v == exp_bad(j), "R4", v, exp_bad(j));
         else
            check(v == exp_bad(j), "R5", v, exp_bad(j));
      end
      // R8: back-to-back lookups of a bad then a good block
      lk_idx = 10'd5;
      @(negedge clk);
      check(lk_bad == 1'b1, "R8", lk_bad, 1);
      lk_idx = 10'd6;
      @(negedge clk);
      check(lk_bad == 1'b0, "R8", lk_bad, 0);

      // stuck device at block 6
      hold_reset();
      stuck_blk = 6;
      for (int j = 0; j < 6; j++) push_block(j, 24);
      push_block(6, 4);
      release_reset();
      wait_end();
      // R9
      check(scan_err == 1'b1 && scan_done == 1'b0, "R9", {scan_err, scan_done}, 2'b10);
      check(err_code == 2'd2, "R9", err_code, 2);
      check(bad_count == 11'd2, "R9", bad_count, 2);
      idle_check("R9");
      lookup(5, v);
      check(v == 1'b1, "R9", v, 1);
      lookup(7, v);
      check(v == 1'b0, "R9", v, 0);

      // transport fault on the 30th byte
      hold_reset();
      stuck_blk = -1;
      err_at = 30;
      push_block(0, 24);
      push_block(1, 6);
      release_reset();
      // R11: map from the previous run is cleared
      lookup(5, v);
      check(v == 1'b0, "R11", v, 0);
      wait_end();
      // R10
      check(scan_err == 1'b1, "R10", scan_err, 1);
      check(err_code == 2'd1, "R10", err_code, 1);
      check(bad_count == 11'd0, "R10", bad_count, 0);
      idle_check("R10");

      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
         $finish;
      end
   end

endmodule